// File: doc/BRIEF.md
# Core Regulator Power-Up Sequencer

This block holds the digital start-up sequence of a multiphase core-voltage controller. Once the regulator is enabled, it waits until an external rail-good signal is high and a comparator reports that the output sits inside the window around the boot voltage. It then times a short qualification delay and drives an active-low clock-enable for the system clock generator. A second, much longer delay is counted from the moment clock-enable asserts. When that delay ends, the block releases its power-good pull-down.

Both delays are counted in cycles of a reference clock whose frequency is a parameter. The nominal power-good delay may be set anywhere in its allowed range of 5.5 ms to 8.1 ms. If any qualifying input is lost, the sequence returns to idle and the timing starts again from zero. A fault input latches the block in a safe state, and only taking the enable low clears it. The power-good pin is open-drain: the block outputs a pull-low enable, and a released pin reads high.

Top module: `pwrseq_top`

## Requirements
- R1: After synchronous reset, `clk_en_n` is 1 and `pgood_pd` is 1, and they stay so until a full sequence has completed.
- R2: While `vr_en` is sampled low, both outputs are inactive (`clk_en_n`=1, `pgood_pd`=1) from the next clock edge on, whatever the other inputs do.
- R3: `clk_en_n` goes low after the edge at which `vr_en`, `rail_good` and `vout_in_win` have been sampled high together on CKEN_CYC consecutive edges. CKEN_CYC = REF_KHZ*CKEN_US/1000, which is 10 at the defaults (1 MHz, 10 us).
- R4: `pgood_pd` goes low (power-good released) exactly PG_CYC edges after the edge at which `clk_en_n` went low. PG_CYC = REF_KHZ*PG_US/1000, which is 6800 at the defaults (6.8 ms).
- R5: With `vr_en` high and no fault latched, a low sample of `rail_good` or `vout_in_win` in any state makes both outputs inactive after that edge. A later sequence then times both delays from zero.
- R6: A high sample of `fault_in` while `vr_en` is high makes both outputs inactive after that edge. They stay inactive, whatever `fault_in`, `rail_good` and `vout_in_win` do, until `vr_en` is sampled low.
- R7: `fault_in` sampled while `vr_en` is low has no effect. A sequence started afterwards runs with normal timing.
- R8: `pgood_pd` is never 0 while `clk_en_n` is 1.
- R9: If a fault or a window loss is sampled on the same edge at which the power-good delay would expire, power-good stays pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| vr_en | input | 1 | Regulator enable, active high |
| rail_good | input | 1 | External rails within regulation |
| vout_in_win | input | 1 | Output within the window around the boot voltage |
| fault_in | input | 1 | Global fault, active high |
| clk_en_n | output | 1 | Clock-generator enable, active low |
| pgood_pd | output | 1 | Power-good pull-down enable; 0 means power-good reads high |

## Verification
Two events can fall in the same cycle: expiry of the power-good delay, and either a fault or a loss of the output window. The bench counts PG_CYC-1 edges from the clock-enable edge. It then raises the fault, or drops the window flag, so that the change is sampled on exactly the expiry edge. It judges the result at the ports, expecting power-good to stay pulled low and clock-enable to be released. A behavioural reference model runs alongside on every clock, so any one-cycle slip in either delay also shows up as a mismatch.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_QUAL  = 3'd1,
    S_CLKON = 3'd2,
    S_GOOD  = 3'd3,
    S_FAULT = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    T_HOLD = 2'd0,
    T_ZERO = 2'd1,
    T_ONE  = 2'd2,
    T_INC  = 2'd3
  } tmr_op_t;

  // Convert a delay in microseconds to reference-clock cycles.
  function automatic int unsigned us_to_cycles(input int unsigned khz,
                                               input int unsigned us);
    longint unsigned prod;
    prod = longint'(khz) * longint'(us);
    return int'(prod / 1000);
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_op_t       op,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (op)
        T_ZERO:  cnt <= '0;
        T_ONE:   cnt <= CW'(1);
        T_INC:   cnt <= cnt + CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R3/R4: the counter is sized for the longest delay and must never wrap
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (op == T_INC) |-> (cnt != {CW{1'b1}}));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CKEN_CYC = 10,
  parameter int PG_CYC   = 6800,
  parameter int CW       = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vr_en,
  input  logic          rail_good,
  input  logic          vout_in_win,
  input  logic          fault_in,
  input  logic [CW-1:0] cnt,
  output tmr_op_t       op,
  output seq_state_t    state_nxt
);

  localparam logic [CW-1:0] CKEN_LAST = CW'(CKEN_CYC - 1);
  localparam logic [CW-1:0] PG_LAST   = CW'(PG_CYC - 1);

  seq_state_t state;
  logic       qualified;

  assign qualified = rail_good & vout_in_win;

  always_comb begin
    state_nxt = state;
    op        = T_HOLD;
    if (!vr_en) begin
      state_nxt = S_IDLE;
      op        = T_ZERO;
    end else if (state == S_FAULT) begin
      state_nxt = S_FAULT;
    end else if (fault_in) begin
      state_nxt = S_FAULT;
      op        = T_ZERO;
    end else if (!qualified) begin
      state_nxt = S_IDLE;
      op        = T_ZERO;
    end else begin
      case (state)
        S_IDLE: begin
          if (CKEN_CYC <= 1) begin
            state_nxt = S_CLKON;
            op        = T_ZERO;
          end else begin
            state_nxt = S_QUAL;
            op        = T_ONE;
          end
        end
        S_QUAL: begin
          if (cnt == CKEN_LAST) begin
            state_nxt = S_CLKON;
            op        = T_ZERO;
          end else begin
            op = T_INC;
          end
        end
        S_CLKON: begin
          if (cnt == PG_LAST) begin
            state_nxt = S_GOOD;
            op        = T_ZERO;
          end else begin
            op = T_INC;
          end
        end
        default: state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nxt;
  end

  // R2: a low enable always returns the sequence to idle
  p_en_low_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !vr_en |=> (state == S_IDLE));

  // R6: a latched fault holds while enable stays high
  p_fault_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_FAULT && vr_en) |=> (state == S_FAULT));

  // R5: loss of rail or window aborts to idle
  p_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (vr_en && state != S_FAULT && !fault_in && !qualified) |=> (state == S_IDLE));

  // R4: power-good is reached only from the clock-enabled state
  p_good_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(state == S_GOOD) |-> ($past(state) == S_CLKON));

endmodule

// File: rtl/pwrseq_outreg.sv
module pwrseq_outreg
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_nxt,
  output logic       clk_en_n,
  output logic       pgood_pd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_n <= 1'b1;
      pgood_pd <= 1'b1;
    end else begin
      clk_en_n <= !(state_nxt == S_CLKON || state_nxt == S_GOOD);
      pgood_pd <= !(state_nxt == S_GOOD);
    end
  end

  // R8: power-good is never released without clock-enable asserted
  p_pg_after_clk_r8: assert property (@(posedge clk) disable iff (rst)
    !pgood_pd |-> !clk_en_n);

  // R4: release of power-good follows a cycle in which clock-enable was low
  p_pg_order_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pgood_pd) |-> !$past(clk_en_n));

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int REF_KHZ = 1000,
  parameter int CKEN_US = 10,
  parameter int PG_US   = 6800
) (
  input  logic clk,
  input  logic rst,
  input  logic vr_en,
  input  logic rail_good,
  input  logic vout_in_win,
  input  logic fault_in,
  output logic clk_en_n,
  output logic pgood_pd
);

  localparam int CKEN_CYC = int'(us_to_cycles(REF_KHZ, CKEN_US));
  localparam int PG_RAW   = int'(us_to_cycles(REF_KHZ, PG_US));
  localparam int PG_CYC   = (PG_RAW < 1) ? 1 : PG_RAW;
  localparam int MAX_CYC  = (CKEN_CYC > PG_CYC) ? CKEN_CYC : PG_CYC;
  localparam int CW       = $clog2(MAX_CYC + 2);

  tmr_op_t       op;
  seq_state_t    state_nxt;
  logic [CW-1:0] cnt;

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .cnt (cnt)
  );

  pwrseq_fsm #(
    .CKEN_CYC (CKEN_CYC),
    .PG_CYC   (PG_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .vr_en       (vr_en),
    .rail_good   (rail_good),
    .vout_in_win (vout_in_win),
    .fault_in    (fault_in),
    .cnt         (cnt),
    .op          (op),
    .state_nxt   (state_nxt)
  );

  pwrseq_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .clk_en_n  (clk_en_n),
    .pgood_pd  (pgood_pd)
  );

  // R6: an accepted fault releases both outputs on the next edge
  p_fault_out_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_in && vr_en) |=> (clk_en_n && pgood_pd));

  // R2: a low enable releases both outputs on the next edge
  p_en_low_out_r2: assert property (@(posedge clk) disable iff (rst)
    !vr_en |=> (clk_en_n && pgood_pd));

endmodule

// File: tb/pwrseq_top_test.sv
module pwrseq_top_test;

  localparam int C = 10;    // 10 us at 1 MHz
  localparam int P = 6800;  // 6.8 ms at 1 MHz

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vr_en = 1'b0, rail_good = 1'b0, vout_in_win = 1'b0, fault_in = 1'b0;
  logic clk_en_n, pgood_pd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  bit m_on, m_good, m_fault;
  int m_q, m_p;

  always #5 clk = ~clk;

  pwrseq_top uut (
    .clk(clk), .rst(rst), .vr_en(vr_en), .rail_good(rail_good),
    .vout_in_win(vout_in_win), .fault_in(fault_in),
    .clk_en_n(clk_en_n), .pgood_pd(pgood_pd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_on = 0; m_good = 0; m_fault = 0; m_q = 0; m_p = 0;
    end else if (!vr_en) begin
      m_on = 0; m_good = 0; m_fault = 0; m_q = 0; m_p = 0;
    end else if (m_fault) begin
      m_on = 0; m_good = 0;
    end else if (fault_in) begin
      m_fault = 1; m_on = 0; m_good = 0; m_q = 0; m_p = 0;
    end else if (!(rail_good && vout_in_win)) begin
      m_on = 0; m_good = 0; m_q = 0; m_p = 0;
    end else if (!m_on) begin
      m_q++;
      if (m_q == C) begin m_on = 1; m_p = 0; end
    end else if (!m_good) begin
      m_p++;
      if (m_p == P) m_good = 1;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(clk_en_n == !m_on, "R3 model clk_en_n", clk_en_n, !m_on);
      check(pgood_pd == !m_good, "R4 model pgood_pd", pgood_pd, !m_good);
      check(!(!pgood_pd && clk_en_n), "R8 order", pgood_pd, 1);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles max", cyc, 150000);
      finish_run();
    end
  end

  task automatic set_in(input bit e, input bit r, input bit w, input bit f);
    @(negedge clk);
    vr_en = e; rail_good = r; vout_in_win = w; fault_in = f;
  endtask

  task automatic wait_clk_low(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (clk_en_n == 1'b0) break;
    end
  endtask

  task automatic wait_pg_rel(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (pgood_pd == 1'b0) break;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(clk_en_n == 1, "R1 reset clk_en_n", clk_en_n, 1);
    check(pgood_pd == 1, "R1 reset pgood_pd", pgood_pd, 1);

    // R2: enable low with everything else good
    set_in(0, 1, 1, 0);
    repeat (20) @(negedge clk);
    check(clk_en_n == 1, "R2 disabled clk_en_n", clk_en_n, 1);

    // R3, R4: full sequence
    set_in(1, 1, 1, 0);
    wait_clk_low(n);
    check(n == C, "R3 clk-enable delay", n, C);
    wait_pg_rel(n);
    check(n == P, "R4 power-good delay", n, P);

    // R5: rail loss from the good state
    set_in(1, 0, 1, 0);
    @(negedge clk);
    check(clk_en_n == 1 && pgood_pd == 1, "R5 rail loss in good", {clk_en_n, pgood_pd}, 3);

    // R5: window loss during qualification restarts timing
    set_in(1, 1, 1, 0);
    repeat (5) @(negedge clk);
    set_in(1, 1, 0, 0);
    @(negedge clk);
    check(clk_en_n == 1, "R5 window loss in qual", clk_en_n, 1);
    set_in(1, 1, 1, 0);
    wait_clk_low(n);
    check(n == C, "R5 restarted delay", n, C);

    // R2: enable drop during the power-good wait
    repeat (100) @(negedge clk);
    set_in(0, 1, 1, 0);
    @(negedge clk);
    check(clk_en_n == 1 && pgood_pd == 1, "R2 enable drop", {clk_en_n, pgood_pd}, 3);

    // R6: fault during qualification latches
    set_in(1, 1, 1, 0);
    repeat (4) @(negedge clk);
    set_in(1, 1, 1, 1);
    @(negedge clk);
    check(clk_en_n == 1 && pgood_pd == 1, "R6 fault entry", {clk_en_n, pgood_pd}, 3);
    set_in(1, 1, 1, 0);
    repeat (40) @(negedge clk);
    check(clk_en_n == 1, "R6 fault held", clk_en_n, 1);
    set_in(0, 1, 1, 0);
    set_in(1, 1, 1, 0);
    wait_clk_low(n);
    check(n == C, "R6 restart after enable cycle", n, C);

    // R6: fault in the good state
    wait_pg_rel(n);
    check(n == P, "R4 power-good delay again", n, P);
    set_in(1, 1, 1, 1);
    @(negedge clk);
    check(clk_en_n == 1 && pgood_pd == 1, "R6 fault in good", {clk_en_n, pgood_pd}, 3);

    // R7: fault while disabled is ignored
    set_in(0, 1, 1, 1);
    repeat (3) @(negedge clk);
    set_in(1, 1, 1, 0);
    wait_clk_low(n);
    check(n == C, "R7 fault ignored while disabled", n, C);

    // R9: fault on the expiry edge
    repeat (P - 2) @(negedge clk);
    set_in(1, 1, 1, 1);
    @(negedge clk);
    check(pgood_pd == 1, "R9 fault at expiry", pgood_pd, 1);
    repeat (20) @(negedge clk);
    check(pgood_pd == 1 && clk_en_n == 1, "R9 fault still held", {clk_en_n, pgood_pd}, 3);

    // R9/R5: window loss on the expiry edge
    set_in(0, 0, 0, 0);
    set_in(1, 1, 1, 0);
    wait_clk_low(n);
    check(n == C, "R3 delay before window test", n, C);
    repeat (P - 2) @(negedge clk);
    set_in(1, 1, 0, 0);
    @(negedge clk);
    check(pgood_pd == 1 && clk_en_n == 1, "R9 window loss at expiry", {clk_en_n, pgood_pd}, 3);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule